// File: doc/BRIEF.md
# Four-Word Burst Write Buffer

This block sits between a pixel write path and a graphics RAM that has a write port four words wide. A mode input picks one of two behaviours. With the mode input low, every incoming pixel goes straight out as a single-word RAM write. Its address has the low two bits cleared, and the lane picked by those two bits is enabled. With the mode input high, pixels are gathered into a group of four. Only the fourth pixel triggers a write: one wide RAM write that carries all four words.

The address of a group's first word, with its two low bits cleared, becomes the group's write address. The host is expected to start each burst on a four-word boundary. A group that never reaches four words is dropped without a trace. A pulse on the address-load input or any change of the mode input throws away a partly filled group. The buffer takes a new pixel in the same cycle that it issues the wide write of the group before, so the host never has to wait. Address counting and the RAM itself are outside this block.

Top module: `burst_write_gather`

## Requirements
- R1: While reset is asserted and after it is released with no input activity, `ram_we` is 0 and `ram_addr`, `ram_lane_en` and `ram_data` are all zero.
- R2: With `fast_mode` low, each cycle with `pix_valid` high produces, one clock later, `ram_we`=1 for that clock. In that write, `ram_addr` is `pix_addr` with bits [1:0] forced to 0. `ram_lane_en` is one-hot, with its set bit at index `pix_addr[1:0]`. `ram_data` holds `pix_data` in that lane, and every other lane is zero. Lane k occupies bits [k*DATA_W +: DATA_W].
- R3: With `fast_mode` high, `ram_we` stays 0 until the fourth accepted pixel of a group. In the clock after that pixel, `ram_we` is 1 for exactly one clock and `ram_lane_en` is 4'b1111.
- R4: In a group write, the k-th accepted pixel of the group (k = 0..3) appears in lane k. `ram_addr` is the address of pixel 0 with bits [1:0] forced to 0.
- R5: If fewer than four pixels of a group arrive and input stops, no RAM write happens.
- R6: An `addr_load` pulse clears any partial group without writing it. A pixel accepted in the same cycle becomes word 0 of a new group.
- R7: A change of `fast_mode` clears any partial group without writing it. A pixel in the same cycle is handled under the new mode; in fast mode it becomes word 0 of a new group.
- R8: Pixels may arrive on every clock without stalls, and back-to-back groups each produce their own write. `ram_we` is never 1 in a clock that does not follow a cycle with `pix_valid` high.
- R9: Whenever `ram_we` is 1, `ram_addr[1:0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 = gather four pixels per write, 0 = single-word writes |
| addr_load | input | 1 | Pulse when the host loads the address register; clears the partial group |
| pix_valid | input | 1 | Pixel write strobe |
| pix_data | input | DATA_W | Pixel word |
| pix_addr | input | ADDR_W | Current address of the pixel |
| ram_we | output | 1 | RAM write strobe, one clock per write |
| ram_addr | output | ADDR_W | Four-word-aligned RAM address |
| ram_lane_en | output | LANES | Per-lane write enable |
| ram_data | output | LANES*DATA_W | Write data, lane k at bits [k*DATA_W +: DATA_W] |

## Verification
The assertions check a set of rules on every cycle. The write address is always aligned. A single-mode pixel always gives a one-hot write on the next clock. A fast-mode pixel never gives a one-hot write. A wide write never repeats on the next clock. No write appears without a pixel in the cycle before. Only the bench's scenarios can show the rest: which lane each word lands in, that the group address comes from the first word, and that partial groups vanish when the address is loaded, the mode changes or the host simply stops. The bench shows these by comparing every output cycle against a model computed from the requirements.

// File: rtl/burst_gather_pkg.sv
package burst_gather_pkg;
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/gather_count.sv
module gather_count #(
   parameter int LANES = 4,
   localparam int LB = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          accept,
   output logic [LB-1:0] slot,
   output logic          group_done
);
   logic [LB-1:0] cnt_q;

   // a clear in this cycle makes the incoming word slot 0
   assign slot       = clear ? '0 : cnt_q;
   assign group_done = accept && (slot == LB'(LANES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (accept) begin
         cnt_q <= group_done ? '0 : slot + LB'(1);
      end else if (clear) begin
         cnt_q <= '0;
      end
   end
endmodule

// File: rtl/gather_lanes.sv
module gather_lanes #(
   parameter int DATA_W = 18,
   parameter int LANES  = 4,
   localparam int LB = $clog2(LANES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [LB-1:0]                 wr_slot,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [(LANES-1)*DATA_W-1:0]   held
);
   // the last lane is never stored: it is taken straight from the input
   for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && (wr_slot == LB'(k))) begin
            word_q <= wr_data;
         end
      end
      assign held[k*DATA_W +: DATA_W] = word_q;
   end
endmodule

// File: rtl/burst_issue.sv
module burst_issue #(
   parameter int DATA_W           = 18,
   parameter int ADDR_W           = 16,
   parameter int LANES            = 4,
   parameter bit CLEAR_IDLE_LANES = 1'b1,
   localparam int LB = $clog2(LANES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        single_go,
   input  logic                        group_go,
   input  logic [ADDR_W-1:0]           pix_addr,
   input  logic [DATA_W-1:0]           pix_data,
   input  logic [ADDR_W-LB-1:0]        group_base,
   input  logic [(LANES-1)*DATA_W-1:0] held,
   output logic                        ram_we,
   output logic [ADDR_W-1:0]           ram_addr,
   output logic [LANES-1:0]            ram_lane_en,
   output logic [LANES*DATA_W-1:0]     ram_data
);
   logic [LB-1:0]           sel;
   logic [LANES*DATA_W-1:0] single_vec;
   logic [LANES*DATA_W-1:0] group_vec;

   assign sel = pix_addr[LB-1:0];

   for (genvar k = 0; k < LANES; k++) begin : g_mux
      if (CLEAR_IDLE_LANES) begin : g_zero
         assign single_vec[k*DATA_W +: DATA_W] = (sel == LB'(k)) ? pix_data : '0;
      end else begin : g_repl
         assign single_vec[k*DATA_W +: DATA_W] = pix_data;
      end
      if (k == LANES - 1) begin : g_live
         assign group_vec[k*DATA_W +: DATA_W] = pix_data;
      end else begin : g_held
         assign group_vec[k*DATA_W +: DATA_W] = held[k*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_we      <= 1'b0;
         ram_addr    <= '0;
         ram_lane_en <= '0;
         ram_data    <= '0;
      end else begin
         ram_we <= single_go || group_go;
         if (single_go) begin
            ram_addr    <= {pix_addr[ADDR_W-1:LB], {LB{1'b0}}};
            ram_lane_en <= LANES'(1) << sel;
            ram_data    <= single_vec;
         end else if (group_go) begin
            ram_addr    <= {group_base, {LB{1'b0}}};
            ram_lane_en <= '1;
            ram_data    <= group_vec;
         end
      end
   end
endmodule

// File: rtl/burst_write_gather.sv
module burst_write_gather #(
   parameter int DATA_W           = 18,
   parameter int ADDR_W           = 16,
   parameter int LANES            = 4,
   parameter bit CLEAR_IDLE_LANES = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fast_mode,
   input  logic                    addr_load,
   input  logic                    pix_valid,
   input  logic [DATA_W-1:0]       pix_data,
   input  logic [ADDR_W-1:0]       pix_addr,
   output logic                    ram_we,
   output logic [ADDR_W-1:0]       ram_addr,
   output logic [LANES-1:0]        ram_lane_en,
   output logic [LANES*DATA_W-1:0] ram_data
);
   import burst_gather_pkg::*;

   localparam int LB = $clog2(LANES);

   if (!is_pow2(LANES) || LANES < 2) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (ADDR_W <= LB) begin : g_bad_addr
      $error("ADDR_W must exceed the lane index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic                        mode_q;
   logic                        clear;
   logic                        accept;
   logic [LB-1:0]               slot;
   logic                        group_done;
   logic [ADDR_W-LB-1:0]        base_q;
   logic [(LANES-1)*DATA_W-1:0] held;

   assign clear  = addr_load || (fast_mode != mode_q);
   assign accept = pix_valid && fast_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         base_q <= '0;
      end else begin
         mode_q <= fast_mode;
         if (accept && (slot == '0)) begin
            base_q <= pix_addr[ADDR_W-1:LB];
         end
      end
   end

   gather_count #(.LANES(LANES)) count_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .accept     (accept),
      .slot       (slot),
      .group_done (group_done)
   );

   gather_lanes #(.DATA_W(DATA_W), .LANES(LANES)) lanes_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept),
      .wr_slot (slot),
      .wr_data (pix_data),
      .held    (held)
   );

   burst_issue #(
      .DATA_W           (DATA_W),
      .ADDR_W           (ADDR_W),
      .LANES            (LANES),
      .CLEAR_IDLE_LANES (CLEAR_IDLE_LANES)
   ) issue_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .single_go   (pix_valid && !fast_mode),
      .group_go    (group_done),
      .pix_addr    (pix_addr),
      .pix_data    (pix_data),
      .group_base  (base_q),
      .held        (held),
      .ram_we      (ram_we),
      .ram_addr    (ram_addr),
      .ram_lane_en (ram_lane_en),
      .ram_data    (ram_data)
   );
endmodule

// File: rtl/burst_gather_chk.sv
module burst_gather_chk #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 16,
   parameter int LANES  = 4,
   localparam int LB = $clog2(LANES)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    fast_mode,
   input logic                    pix_valid,
   input logic                    ram_we,
   input logic [ADDR_W-1:0]       ram_addr,
   input logic [LANES-1:0]        ram_lane_en,
   input logic [LANES*DATA_W-1:0] ram_data
);
   logic unused_data;
   assign unused_data = ^ram_data;

   assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ram_addr[LB-1:0] == '0));

   assert_single_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !fast_mode) |=> (ram_we && $onehot(ram_lane_en)));

   assert_fast_not_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && fast_mode) |=> !(ram_we && $onehot(ram_lane_en)));

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && (&ram_lane_en)) |=> !(ram_we && (&ram_lane_en)));

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !ram_we);

   assert_lane_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ($onehot(ram_lane_en) || (&ram_lane_en)));
endmodule

bind burst_write_gather burst_gather_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .LANES  (LANES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .fast_mode   (fast_mode),
   .pix_valid   (pix_valid),
   .ram_we      (ram_we),
   .ram_addr    (ram_addr),
   .ram_lane_en (ram_lane_en),
   .ram_data    (ram_data)
);

// File: tb/burst_write_gather_tb_top.sv
module burst_write_gather_tb_top;
   localparam int DW = 8;
   localparam int AW = 6;
   localparam int L  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fast_mode = 1'b0;
   logic          addr_load = 1'b0;
   logic          pix_valid = 1'b0;
   logic [DW-1:0] pix_data = '0;
   logic [AW-1:0] pix_addr = '0;
   logic          ram_we;
   logic [AW-1:0] ram_addr;
   logic [L-1:0]  ram_lane_en;
   logic [L*DW-1:0] ram_data;

   int compared = 0;
   int mismatched = 0;
   string cur_req = "R1";

   // reference model state
   int            m_cnt = 0;
   logic          m_mode = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [DW-1:0] m_buf [L];
   logic          e_we;
   logic [AW-1:0] e_addr;
   logic [L-1:0]  e_en;
   logic [L*DW-1:0] e_data;

   always #10 clk = ~clk;

   burst_write_gather #(.DATA_W(DW), .ADDR_W(AW), .LANES(L)) dut_i (
      .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .addr_load(addr_load),
      .pix_valid(pix_valid), .pix_data(pix_data), .pix_addr(pix_addr),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_lane_en(ram_lane_en),
      .ram_data(ram_data)
   );

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired (req %s) actual=hung expected=finish", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   task automatic step(input logic v, input logic [DW-1:0] d,
                       input logic [AW-1:0] a, input logic ld, input logic m);
      pix_valid = v; pix_data = d; pix_addr = a; addr_load = ld; fast_mode = m;
      @(posedge clk);
      // model from the requirements
      e_we = 1'b0;
      if (ld || (m != m_mode)) m_cnt = 0;
      if (v && !m) begin
         e_we   = 1'b1;
         e_addr = a & ~AW'(3);
         e_en   = L'(1) << a[1:0];
         e_data = (L*DW)'(d) << (DW * a[1:0]);
      end else if (v && m) begin
         if (m_cnt == 0) m_base = a & ~AW'(3);
         m_buf[m_cnt] = d;
         if (m_cnt == L - 1) begin
            e_we   = 1'b1;
            e_addr = m_base;
            e_en   = '1;
            e_data = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
            m_cnt  = 0;
         end else begin
            m_cnt++;
         end
      end
      m_mode = m;
      @(negedge clk);
      compared++;
      if (ram_we !== e_we) begin
         mismatched++;
         $display("FAIL %s ram_we actual=%0b expected=%0b", cur_req, ram_we, e_we);
      end
      if (e_we) begin
         compared++;
         if (ram_addr !== e_addr || ram_lane_en !== e_en || ram_data !== e_data) begin
            mismatched++;
            $display("FAIL %s write actual=%h/%b/%h expected=%h/%b/%h", cur_req,
                     ram_addr, ram_lane_en, ram_data, e_addr, e_en, e_data);
         end
      end
   endtask

   task automatic idle(input int n, input logic m);
      for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, m);
   endtask

   initial begin
      for (int i = 0; i < L; i++) m_buf[i] = '0;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      compared++;
      if (ram_we !== 1'b0 || ram_addr !== '0 || ram_lane_en !== '0 || ram_data !== '0) begin
         mismatched++;
         $display("FAIL R1 reset actual=%b/%h/%b/%h expected=0/0/0/0",
                  ram_we, ram_addr, ram_lane_en, ram_data);
      end
      rst_n = 1'b1;
      idle(3, 1'b0);

      // R2: single-word forwarding over every address
      cur_req = "R2";
      for (int a = 0; a < 64; a++) step(1'b1, DW'(a * 5 + 3), AW'(a), 1'b0, 1'b0);
      idle(2, 1'b0);

      // R3/R4/R8: back-to-back aligned groups
      cur_req = "R3";
      idle(1, 1'b1);
      for (int g = 0; g < 16; g++)
         for (int k = 0; k < 4; k++)
            step(1'b1, DW'(g * 16 + k * 3 + 1), AW'(g * 4 + k), 1'b0, 1'b1);
      cur_req = "R8";
      idle(3, 1'b1);
      for (int g = 0; g < 6; g++)
         for (int k = 0; k < 4; k++) begin
            step(1'b1, DW'(g * 29 + k * 7), AW'(32 + g * 4 + k), 1'b0, 1'b1);
            if ((g + k) % 3 == 0) idle(1 + k, 1'b1);
         end

      // R5: partial groups then stop, then R6 clear by address load
      for (int n = 1; n < 4; n++) begin
         cur_req = "R5";
         for (int k = 0; k < n; k++) step(1'b1, DW'(200 + k), AW'(8 + k), 1'b0, 1'b1);
         idle(5, 1'b1);
         cur_req = "R6";
         step(1'b0, '0, AW'(20), 1'b1, 1'b1);
         for (int k = 0; k < 4; k++) step(1'b1, DW'(100 + n * 8 + k), AW'(20 + k), 1'b0, 1'b1);
      end

      // R6: address load with a pixel in the same cycle starts a new group
      cur_req = "R6";
      for (int n = 1; n < 4; n++) begin
         for (int k = 0; k < n; k++) step(1'b1, DW'(50 + k), AW'(4 + k), 1'b0, 1'b1);
         step(1'b1, DW'(170 + n), AW'(40), 1'b1, 1'b1);
         for (int k = 1; k < 4; k++) step(1'b1, DW'(170 + n + k * 11), AW'(40 + k), 1'b0, 1'b1);
      end

      // R7: mode change drops the partial group
      cur_req = "R7";
      for (int n = 1; n < 4; n++) begin
         for (int k = 0; k < n; k++) step(1'b1, DW'(60 + k), AW'(12 + k), 1'b0, 1'b1);
         step(1'b1, DW'(90 + n), AW'(n + 16), 1'b0, 1'b0);
         for (int k = 0; k < 4; k++) step(1'b1, DW'(140 + n * 4 + k), AW'(48 + k), 1'b0, 1'b1);
      end
      for (int k = 0; k < 2; k++) step(1'b1, DW'(77 + k), AW'(k), 1'b0, 1'b1);
      idle(1, 1'b0);
      idle(1, 1'b1);
      cur_req = "R9";
      for (int k = 0; k < 4; k++) step(1'b1, DW'(33 + k), AW'(56 + k), 1'b0, 1'b1);
      idle(4, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule